// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer for catching a hung processor. A free-running prescaler produces a tick four times per detection period. A two-bit stage counter counts those ticks. When the counter passes its top value, the watchdog fires. Depending on a control bit, it either raises a reset request or issues an interrupt pulse. The watchdog runs from the moment reset is released, and no software set-up is needed.

Software keeps the watchdog quiet by writing a fixed key value to a kick register. The kick restarts only the stage counter and leaves the prescaler running. The time from a kick to a firing therefore lies between three quarters of the selected period and the full period. Software must kick at intervals shorter than three quarters of the period.

A pause input freezes both the prescaler and the counter while the system sits in a low-power state. When the input drops, counting continues from the held values.

Top module: `wdog_prescaled`

## Requirements
- R1: After reset the outputs are low and the watchdog runs without any write. The reset value of the control register selects span code 00 and the reset-request output, so `rst_req` rises between 3T/4 and T+2 cycles after reset release, where T is the period for code 00.
- R2: A write with `wr_addr`=0 updates the control register. Bits [2:1] give the span code c, which sets the period T = 2^(TIME_LOG2_MIN+6-2c) cycles. Bit 3 selects the output: 1 gives a reset request and 0 gives an interrupt. All other bits are ignored.
- R3: A write of 0x4E with `wr_addr`=1 (a kick) restarts the stage counter but not the prescaler. After a kick with no further kick, the watchdog fires between 3T/4 and T+2 cycles later.
- R4: Kicks repeated every T/2 cycles keep both outputs low indefinitely.
- R5: A write with `wr_addr`=1 of any value other than 0x4E has no effect on the time to firing.
- R6: In reset-request mode, `rst_req` is a level. Once set, it stays high, even across kicks, until `rst_n` is asserted.
- R7: In interrupt mode, each firing gives a one-cycle pulse on `wdt_irq`. The counter wraps and keeps running, so pulses repeat exactly T cycles apart, and `rst_req` stays low.
- R8: While `pause` is high, neither the prescaler nor the counter advances, and no firing can occur. After `pause` drops, counting resumes from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 1 | 0 = control register, 1 = kick register |
| wr_data | input | 8 | Write data |
| pause | input | 1 | Low-power freeze of all counting |
| rst_req | output | 1 | Sticky reset request |
| wdt_irq | output | 1 | One-cycle watchdog interrupt pulse |

## Verification
The assertions check, on every cycle, the relations that hold locally:
- the prescaler holds its state during a pause;
- a kick zeroes the stage counter;
- the counter steps by one per tick;
- an overflow in reset mode sets the request, and the request never falls;
- an interrupt pulse never lasts two cycles.

Only the bench scenarios can show the end-to-end timing. These cover the firing window for each span code, the immunity gained by regular kicks, and the lack of effect of wrong key values. They also cover the exact interrupt spacing and the remaining time after a long pause.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Register addresses and the kick key.
  localparam logic       ADDR_CTRL = 1'b0;
  localparam logic       ADDR_KICK = 1'b1;
  localparam logic [7:0] KICK_KEY  = 8'h4E;

  typedef struct packed {
    logic [1:0] span;       // period select, 00 = longest
    logic       to_reset;   // 1: reset request, 0: interrupt
  } wdog_ctrl_t;

  localparam wdog_ctrl_t CTRL_RESET = '{span: 2'b00, to_reset: 1'b1};

  // log2 of the prescaler tick period for a given span code.
  function automatic int tick_log2(input int min_log2, input int code);
    return min_log2 - 2 + 2 * (3 - code);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output wdog_ctrl_t ctrl,
  output logic       kick
);
  wdog_ctrl_t ctrl_q;
  logic       unused_bits;

  assign unused_bits = ^{wr_data[7:4], wr_data[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_en && wr_addr == ADDR_CTRL) begin
      ctrl_q.span     <= wr_data[2:1];
      ctrl_q.to_reset <= wr_data[3];
    end
  end

  assign ctrl = ctrl_q;
  assign kick = wr_en && (wr_addr == ADDR_KICK) && (wr_data == KICK_KEY);
endmodule

// File: rtl/wdog_divider.sv
module wdog_divider
  import wdog_pkg::*;
#(
  parameter int TIME_LOG2_MIN = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic [1:0] span,
  output logic       tick
);
  localparam int DIV_W = tick_log2(TIME_LOG2_MIN, 0);

  logic [DIV_W-1:0] div_q;
  logic [3:0]       tick_opt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= '0;
    else if (!hold) div_q <= div_q + 1'b1;
  end

  // One tick candidate per span code: the low bits of the prescaler all ones.
  for (genvar g = 0; g < 4; g++) begin : g_tap
    localparam int TL = tick_log2(TIME_LOG2_MIN, g);
    assign tick_opt[g] = &div_q[TL-1:0];
  end

  assign tick = !hold && tick_opt[span];

  assert_pause_holds_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(div_q));
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic kick,
  output logic ovf
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (kick) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign ovf = tick && !kick && (cnt_q == TOP);

  assert_clear_zeroes_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> cnt_q == '0);
  assert_count_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !kick && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_idle_stable_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !kick) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int TIME_LOG2_MIN = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       pause,
  output logic       rst_req,
  output logic       wdt_irq
);
  wdog_ctrl_t ctrl;
  logic       kick;
  logic       tick;
  logic       ovf;
  logic       req_q;
  logic       irq_q;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .kick(kick)
  );

  wdog_divider #(.TIME_LOG2_MIN(TIME_LOG2_MIN)) u_div (
    .clk(clk), .rst_n(rst_n), .hold(pause), .span(ctrl.span), .tick(tick)
  );

  wdog_stage #(.CNT_W(2)) u_stage (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .ovf(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      req_q <= req_q | (ovf && ctrl.to_reset);
      irq_q <= ovf && !ctrl.to_reset;
    end
  end

  assign rst_req = req_q;
  assign wdt_irq = irq_q;

  assert_ovf_sets_req_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && ctrl.to_reset) |=> rst_req);
  assert_req_sticky_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  assert_irq_single_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |=> !wdt_irq);
endmodule

// File: tb/wdog_prescaled_tb.sv
module wdog_prescaled_tb;
  localparam int MINL = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       pause = 1'b0;
  logic       rst_req;
  logic       wdt_irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  wdog_prescaled #(.TIME_LOG2_MIN(MINL)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pause(pause), .rst_req(rst_req), .wdt_irq(wdt_irq)
  );

  function automatic int period(input int code);
    return 1 << (MINL + 6 - 2 * code);
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pause = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_req(output int n, input int limit);
    n = 0;
    while (!rst_req && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  // R9-like reset state and R1 default self-start
  task automatic t_reset_default();
    int n;
    do_reset();
    chk_eq("R1 rst_req after reset", rst_req, 0);
    chk_eq("R1 wdt_irq after reset", wdt_irq, 0);
    wait_req(n, 3000);
    chk_rng("R1 default firing time", n, 3 * period(0) / 4, period(0) + 2);
  endtask

  // R2 span codes with R3 window after a kick
  task automatic t_span_codes();
    int n;
    for (int c = 0; c < 4; c++) begin
      do_reset();
      reg_write(1'b0, 8'hF1 & 8'hF0 | 8'h08 | 8'(c << 1));
      reg_write(1'b1, 8'h4E);
      wait_req(n, 3000);
      chk_rng($sformatf("R2 R3 firing window code %0d", c), n,
              3 * period(c) / 4, period(c) + 2);
    end
  endtask

  // R4 regular kicks at T/2 hold the outputs low
  task automatic t_keepalive();
    int hits = 0;
    do_reset();
    reg_write(1'b0, 8'h0E);
    for (int k = 0; k < 20; k++) begin
      reg_write(1'b1, 8'h4E);
      repeat (period(3) / 2 - 2) begin
        @(negedge clk);
        if (rst_req) hits++;
      end
    end
    chk_eq("R4 no firing with regular kicks", hits, 0);
  endtask

  // R5 wrong key values do not restart the counter
  task automatic t_bad_key();
    int n = 0;
    logic [7:0] bad [3] = '{8'h4F, 8'h0E, 8'hCE};
    do_reset();
    reg_write(1'b0, 8'h0C);
    reg_write(1'b1, 8'h4E);
    while (!rst_req && n < 400) begin
      @(negedge clk);
      n++;
      wr_en = (n % 20 == 0);
      wr_addr = 1'b1;
      wr_data = bad[n % 3];
    end
    wr_en = 1'b0;
    chk_rng("R5 wrong key ignored", n, 3 * period(2) / 4, period(2) + 2);
  endtask

  // R6 reset request is sticky until rst_n
  task automatic t_sticky();
    int n;
    int drops = 0;
    do_reset();
    reg_write(1'b0, 8'h0E);
    wait_req(n, 100);
    chk_eq("R6 request raised", rst_req, 1);
    for (int k = 0; k < 6; k++) begin
      reg_write(1'b1, 8'h4E);
      repeat (20) begin
        @(negedge clk);
        if (!rst_req) drops++;
      end
    end
    chk_eq("R6 request held across kicks", drops, 0);
    do_reset();
    chk_eq("R6 request cleared by reset", rst_req, 0);
  endtask

  // R7 interrupt pulses, width one, spacing T, no reset request
  task automatic t_irq();
    int n = 0;
    do_reset();
    reg_write(1'b0, 8'h06);
    reg_write(1'b1, 8'h4E);
    while (!wdt_irq && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk_eq("R7 first pulse seen", wdt_irq, 1);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) chk_eq("R7 pulse width one cycle", wdt_irq, 0);
    end while (!wdt_irq && n < 100);
    chk_eq("R7 pulse spacing", n, period(3));
    chk_eq("R7 no reset request in interrupt mode", rst_req, 0);
  endtask

  // R8 pause freezes counting, resumes from held state
  task automatic t_pause();
    int n;
    int hits = 0;
    do_reset();
    reg_write(1'b0, 8'h0C);
    reg_write(1'b1, 8'h4E);
    repeat (period(2) / 2) @(negedge clk);
    pause = 1'b1;
    repeat (3 * period(2)) begin
      @(negedge clk);
      if (rst_req) hits++;
    end
    chk_eq("R8 no firing while paused", hits, 0);
    pause = 1'b0;
    wait_req(n, 400);
    chk_rng("R8 remaining time after pause", n,
            period(2) / 4 - 2, period(2) / 2 + 4);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_default();
    t_span_codes();
    t_keepalive();
    t_bad_key();
    t_sticky();
    t_irq();
    t_pause();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule